// File: doc/BRIEF.md
# Single-Bit Test and Clear Execution Unit

This unit carries out the bit-test and bit-test-and-clear instructions of a processor with 16-bit opcode words. It decodes the opcode to find three things: whether the bit number comes from a data register or from an immediate extension word, whether the selected bit is only tested or is also cleared, and whether the operand is a 32-bit data register or a single memory byte. From the old value of the selected bit it produces the Zero flag. For the clearing form it also produces the operand with that bit forced low and a write-back strobe. It reports how many processor clock cycles the instruction takes.

The surrounding core works out the effective address and performs the bus transfers. For a memory operand the core presents the fetched byte together with a tag that gives the addressing form. The core pulses `start` with all operands valid. The results appear on the registered outputs one clock later, and `done` marks that cycle.

Top module: `bitop_unit`

## Requirements
- R1: Decode: opcode bit 8 = 1 takes the bit number from `reg_bitnum`; bit 8 = 0 takes it from `ext_word`. Opcode bit 7 = 1 selects test-and-clear and 0 selects test only. Opcode bits 5:3 = 000 selects the data-register operand `reg_operand`; any other value selects the memory byte `mem_byte`.
- R2: For a register operand the bit index is the bit number modulo 32 (its low 5 bits), so an index of 50 acts on bit 18.
- R3: For a memory operand the bit index is the bit number modulo 8 (its low 3 bits), so an index of 50 acts on bit 2. `result[31:8]` is 0 and `result[7:0]` carries the byte.
- R4: `zero` is 1 when the selected bit was 0 before any change, and 0 when that bit was 1.
- R5: Test-and-clear returns the operand with the selected bit forced to 0 and raises `wr_en` together with `done`.
- R6: Test only returns the operand unchanged and keeps `wr_en` low.
- R7: Cycle count for test only. The base is 6 with a register operand and 8 with a memory byte. An immediate bit number adds 4. With a memory byte, the absolute-short form (`mem_form` = 1) adds 4 over register-indirect (`mem_form` = 0). This gives 6, 8, 10 and 16 for the four standard forms.
- R8: Cycle count for test-and-clear. The base is 8 with a register operand and 12 with a memory byte. An immediate bit number adds 4, and the absolute-short form adds 4. A register operand with a bit index of 16 or higher adds 2. This gives 8/10 for register-to-register, 12/14 for immediate-to-register, 12 for register-indirect memory and 20 for immediate absolute-short memory.
- R9: Bits of the bit number above the modulo width are ignored. This includes the upper bits of the immediate extension word.
- R10: `done` is high exactly in the cycle after a cycle with `start` high. `result`, `zero` and `cycles` hold their values until the next start.
- R11: While `rst` is high, and after it, `done`, `wr_en`, `zero`, `result` and `cycles` are 0 until the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Operands valid, begin operation |
| opcode | input | 16 | Instruction opcode word |
| ext_word | input | 16 | Immediate extension word holding the bit number |
| reg_bitnum | input | 32 | Data register value used as the bit number |
| reg_operand | input | 32 | Data register operand |
| mem_byte | input | 8 | Memory byte operand |
| mem_form | input | 1 | Memory addressing form: 0 register-indirect, 1 absolute short |
| result | output | 32 | Operand after the operation |
| zero | output | 1 | Updated Zero flag |
| wr_en | output | 1 | Write-back strobe for the operand |
| cycles | output | 5 | Instruction cycle count |
| done | output | 1 | Result valid pulse |

## Verification
The assertions assume that the operands presented with `start` are the values of the instruction that `done` reports one clock later. They also assume that `start` is low during reset. The bench therefore keeps every operand stable across the start cycle and holds `start` low during and right after reset. Only opcodes of the test and clear families are driven, so each decoded operation is defined by the requirements.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic {
    FORM_INDIRECT  = 1'b0,
    FORM_ABS_SHORT = 1'b1
  } mem_form_e;

  typedef struct packed {
    logic imm_src;
    logic do_clear;
    logic to_mem;
  } bitop_ctl_t;
endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
#(
  parameter int OPC_W = 16
) (
  input  logic [OPC_W-1:0] opcode,
  output bitop_ctl_t       ctl
);
  logic unused_bits;
  assign unused_bits = ^{opcode[OPC_W-1:9], opcode[6], opcode[2:0]};

  always_comb begin
    ctl.imm_src  = ~opcode[8];
    ctl.do_clear = opcode[7];
    ctl.to_mem   = (opcode[5:3] != 3'b000);
  end
endmodule

// File: rtl/bitop_core.sv
module bitop_core
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  bitop_ctl_t        ctl,
  input  logic [DATA_W-1:0] bitnum,
  input  logic [DATA_W-1:0] operand,
  input  logic [BYTE_W-1:0] mem_byte,
  output logic [DATA_W-1:0] new_val,
  output logic              old_bit,
  output logic              hi_index
);
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int BIDX_W = $clog2(BYTE_W);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] sel;
  logic [DATA_W-1:0] mask;
  logic              unused_hi;

  assign unused_hi = ^bitnum[DATA_W-1:IDX_W];

  always_comb begin
    if (ctl.to_mem) begin
      idx = {{(IDX_W-BIDX_W){1'b0}}, bitnum[BIDX_W-1:0]};
      sel = {{(DATA_W-BYTE_W){1'b0}}, mem_byte};
    end else begin
      idx = bitnum[IDX_W-1:0];
      sel = operand;
    end
    mask     = {{(DATA_W-1){1'b0}}, 1'b1} << idx;
    old_bit  = |(sel & mask);
    new_val  = ctl.do_clear ? (sel & ~mask) : sel;
    hi_index = ~ctl.to_mem & idx[IDX_W-1];
  end
endmodule

// File: rtl/bitop_cycles.sv
module bitop_cycles
  import bitop_pkg::*;
#(
  parameter int CYC_W     = 5,
  parameter int TEST_REG  = 6,
  parameter int TEST_MEM  = 8,
  parameter int CLR_REG   = 8,
  parameter int CLR_MEM   = 12,
  parameter int IMM_EXTRA = 4,
  parameter int ABS_EXTRA = 4,
  parameter int HI_EXTRA  = 2
) (
  input  bitop_ctl_t       ctl,
  input  logic             abs_form,
  input  logic             hi_index,
  output logic [CYC_W-1:0] cycles
);
  logic [CYC_W-1:0] base;
  logic [CYC_W-1:0] add_imm;
  logic [CYC_W-1:0] add_abs;
  logic [CYC_W-1:0] add_hi;

  always_comb begin
    case ({ctl.do_clear, ctl.to_mem})
      2'b00:   base = CYC_W'(TEST_REG);
      2'b01:   base = CYC_W'(TEST_MEM);
      2'b10:   base = CYC_W'(CLR_REG);
      default: base = CYC_W'(CLR_MEM);
    endcase
    add_imm = ctl.imm_src ? CYC_W'(IMM_EXTRA) : '0;
    add_abs = (ctl.to_mem && abs_form) ? CYC_W'(ABS_EXTRA) : '0;
    add_hi  = (ctl.do_clear && hi_index) ? CYC_W'(HI_EXTRA) : '0;
    cycles  = base + add_imm + add_abs + add_hi;
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int OPC_W  = 16,
  parameter int EXT_W  = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [EXT_W-1:0]  ext_word,
  input  logic [DATA_W-1:0] reg_bitnum,
  input  logic [DATA_W-1:0] reg_operand,
  input  logic [BYTE_W-1:0] mem_byte,
  input  logic              mem_form,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              wr_en,
  output logic [CYC_W-1:0]  cycles,
  output logic              done
);
  bitop_ctl_t        ctl;
  logic [DATA_W-1:0] bitnum;
  logic [DATA_W-1:0] new_val;
  logic              old_bit;
  logic              hi_index;
  logic [CYC_W-1:0]  cyc_next;

  bitop_decode #(.OPC_W(OPC_W)) u_dec (
    .opcode (opcode),
    .ctl    (ctl)
  );

  assign bitnum = ctl.imm_src ? {{(DATA_W-EXT_W){1'b0}}, ext_word} : reg_bitnum;

  bitop_core #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_core (
    .ctl      (ctl),
    .bitnum   (bitnum),
    .operand  (reg_operand),
    .mem_byte (mem_byte),
    .new_val  (new_val),
    .old_bit  (old_bit),
    .hi_index (hi_index)
  );

  bitop_cycles #(.CYC_W(CYC_W)) u_cyc (
    .ctl      (ctl),
    .abs_form (mem_form == FORM_ABS_SHORT),
    .hi_index (hi_index),
    .cycles   (cyc_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      zero   <= 1'b0;
      wr_en  <= 1'b0;
      cycles <= '0;
      done   <= 1'b0;
    end else begin
      done  <= start;
      wr_en <= start & ctl.do_clear;
      if (start) begin
        result <= new_val;
        zero   <= ~old_bit;
        cycles <= cyc_next;
      end
    end
  end
endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int OPC_W  = 16,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int CYC_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [OPC_W-1:0]  opcode,
  input logic [DATA_W-1:0] reg_operand,
  input logic [BYTE_W-1:0] mem_byte,
  input logic [DATA_W-1:0] result,
  input logic              zero,
  input logic              wr_en,
  input logic [CYC_W-1:0]  cycles,
  input logic              done
);
  logic [DATA_W-1:0] opnd_sel;
  assign opnd_sel = (opcode[5:3] != 3'b000) ? {{(DATA_W-BYTE_W){1'b0}}, mem_byte} : reg_operand;

  assert_done_follows_start_R10: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  assert_done_needs_start_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));
  assert_wr_only_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);
  assert_clear_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($countones(result ^ $past(opnd_sel)) <= 1));
  assert_zero_no_change_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && zero) |-> (result == $past(opnd_sel)));
  assert_test_unchanged_R6: assert property (@(posedge clk) disable iff (rst)
    (done && !wr_en) |-> (result == $past(opnd_sel)));
  assert_cycle_range_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cycles[0] && cycles >= CYC_W'(6) && cycles <= CYC_W'(20)));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && !$past(rst)) |-> ($stable(result) && $stable(cycles) && $stable(zero)));
endmodule

bind bitop_unit bitop_unit_chk #(.OPC_W(OPC_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .opcode(opcode), .reg_operand(reg_operand),
  .mem_byte(mem_byte), .result(result), .zero(zero), .wr_en(wr_en), .cycles(cycles), .done(done)
);

// File: tb/bitop_unit_test.sv
module bitop_unit_test;
  typedef struct packed {
    logic [15:0] op;
    logic [15:0] ext;
    logic [31:0] bn;
    logic [31:0] opnd;
    logic [7:0]  mb;
    logic        form;
    logic [31:0] res;
    logic        z;
    logic        wr;
    logic [4:0]  cyc;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{16'h0300, 16'h0000, 32'd0,  32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b1, 1'b0, 5'd6},
    '{16'h0300, 16'h0000, 32'd10, 32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b0, 1'b0, 5'd6},
    '{16'h0300, 16'h0000, 32'd49, 32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b1, 1'b0, 5'd6},
    '{16'h0380, 16'h0000, 32'd0,  32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b1, 1'b1, 5'd8},
    '{16'h0380, 16'h0000, 32'd10, 32'h12345678, 8'h00, 1'b0, 32'h12345278, 1'b0, 1'b1, 5'd8},
    '{16'h0380, 16'h0000, 32'd50, 32'h12345678, 8'h00, 1'b0, 32'h12305678, 1'b0, 1'b1, 5'd10},
    '{16'h0390, 16'h0000, 32'd50, 32'h0,        8'h78, 1'b0, 32'h00000078, 1'b1, 1'b1, 5'd12},
    '{16'h0390, 16'h0000, 32'd3,  32'h0,        8'h78, 1'b0, 32'h00000070, 1'b0, 1'b1, 5'd12},
    '{16'h0310, 16'h0000, 32'd50, 32'h0,        8'h78, 1'b0, 32'h00000078, 1'b1, 1'b0, 5'd8},
    '{16'h0310, 16'h0000, 32'd3,  32'h0,        8'h78, 1'b0, 32'h00000078, 1'b0, 1'b0, 5'd8},
    '{16'h0800, 16'd28,   32'd0,  32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b0, 1'b0, 5'd10},
    '{16'h0800, 16'd2,    32'd0,  32'h12345678, 8'h00, 1'b0, 32'h12345678, 1'b1, 1'b0, 5'd10},
    '{16'h0880, 16'd28,   32'd0,  32'h12345678, 8'h00, 1'b0, 32'h02345678, 1'b0, 1'b1, 5'd14},
    '{16'h0880, 16'd4,    32'd0,  32'h12345678, 8'h00, 1'b0, 32'h12345668, 1'b0, 1'b1, 5'd12},
    '{16'h0838, 16'd6,    32'd0,  32'h0,        8'h78, 1'b1, 32'h00000078, 1'b0, 1'b0, 5'd16},
    '{16'h08b8, 16'd6,    32'd0,  32'h0,        8'h78, 1'b1, 32'h00000038, 1'b0, 1'b1, 5'd20},
    '{16'h0890, 16'd1,    32'd0,  32'h0,        8'h78, 1'b0, 32'h00000078, 1'b1, 1'b1, 5'd16}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] opcode = '0;
  logic [15:0] ext_word = '0;
  logic [31:0] reg_bitnum = '0;
  logic [31:0] reg_operand = '0;
  logic [7:0]  mem_byte = '0;
  logic        mem_form = 1'b0;
  logic [31:0] result;
  logic        zero;
  logic        wr_en;
  logic [4:0]  cycles;
  logic        done;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bitop_unit uut (
    .clk(clk), .rst(rst), .start(start), .opcode(opcode), .ext_word(ext_word),
    .reg_bitnum(reg_bitnum), .reg_operand(reg_operand), .mem_byte(mem_byte),
    .mem_form(mem_form), .result(result), .zero(zero), .wr_en(wr_en),
    .cycles(cycles), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input vec_t v);
    @(negedge clk);
    opcode = v.op; ext_word = v.ext; reg_bitnum = v.bn;
    reg_operand = v.opnd; mem_byte = v.mb; mem_form = v.form;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #3000000;
    total++;
    fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 done in reset", {31'd0, done}, 32'd0);
    chk("R11 result in reset", result, 32'd0);
    chk("R11 cycles in reset", {27'd0, cycles}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 wr_en after reset", {31'd0, wr_en}, 32'd0);
    chk("R11 zero after reset", {31'd0, zero}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i]);
      chk("R10 done pulse", {31'd0, done}, 32'd1);
      chk("R1 R2 R3 R5 R6 result", result, VECS[i].res);
      chk("R4 zero flag", {31'd0, zero}, {31'd0, VECS[i].z});
      chk("R5 R6 write-back", {31'd0, wr_en}, {31'd0, VECS[i].wr});
      chk("R7 R8 cycle count", {27'd0, cycles}, {27'd0, VECS[i].cyc});
    end

    // R9: upper immediate bits ignored; 0xFFE4 acts as bit 4 on a register
    run_op('{16'h0880, 16'hFFE4, 32'd0, 32'h12345678, 8'h00, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0});
    chk("R9 immediate upper bits result", result, 32'h12345668);
    chk("R9 immediate upper bits cycles", {27'd0, cycles}, 32'd12);
    // R9: memory byte, 0xFFFB keeps bit 3 (set in 0x78)
    run_op('{16'h08b8, 16'hFFFB, 32'd0, 32'h0, 8'h78, 1'b1, 32'h0, 1'b0, 1'b0, 5'd0});
    chk("R9 memory upper bits result", result, 32'h00000070);
    chk("R9 memory upper bits zero", {31'd0, zero}, 32'd0);
    // R9: register bit number above bit 4 ignored (0xFFFFFFE0 -> bit 0)
    run_op('{16'h0380, 16'h0, 32'hFFFFFFE0, 32'h00000001, 8'h00, 1'b0, 32'h0, 1'b0, 1'b0, 5'd0});
    chk("R9 register bitnum upper bits", result, 32'h00000000);
    chk("R8 low index cycles", {27'd0, cycles}, 32'd8);
    // R7: register bit number with absolute-short byte
    run_op('{16'h0338, 16'h0, 32'd3, 32'h0, 8'h78, 1'b1, 32'h0, 1'b0, 1'b0, 5'd0});
    chk("R7 reg bitnum abs short cycles", {27'd0, cycles}, 32'd12);
    chk("R3 byte zero-extended", result, 32'h00000078);

    // R10: single pulse and hold
    @(negedge clk);
    chk("R10 done drops", {31'd0, done}, 32'd0);
    chk("R10 wr_en drops", {31'd0, wr_en}, 32'd0);
    reg_operand = 32'hFFFFFFFF; mem_byte = 8'h00; opcode = 16'h0380;
    @(negedge clk);
    chk("R10 result held", result, 32'h00000078);
    chk("R10 cycles held", {27'd0, cycles}, 32'd12);

    // R11: reset clears outputs
    rst = 1'b1;
    @(negedge clk);
    chk("R11 result after mid reset", result, 32'd0);
    chk("R11 cycles after mid reset", {27'd0, cycles}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule